// File: doc/BRIEF.md
# SDRAM Open-Row Bank Tracker

This block sits between an access requester and the command pins of an SDRAM with four internal banks. For each bank it remembers whether a row is open and, if so, which one. When a read or write request arrives it compares the requested row against that memory and chooses the shortest legal command sequence. A hit goes straight to the column command. A closed bank gets an activate first. A row conflict gets a precharge of that bank alone, then an activate, then the column command.

The wait after an activate and the wait after a precharge are each taken from a configuration input. NOP commands fill those waits. A one-cycle ready pulse marks the column command of each access. The requester holds its request until that pulse and drops it in the same cycle. A separate input tells the tracker that every bank has been closed elsewhere, for example by a precharge-all issued by another agent.

Top module: `sdram_row_tracker`

## Requirements
- R1: After reset every bank is treated as closed, `cmd_o` is NOP (0) and `req_ready` is low. The first access to any bank therefore begins with an activate.
- R2: A request to a closed bank issues ACT (1) in the cycle after acceptance, with the bank on `ba_o` and the row on `addr_o`. The column command follows it.
- R3: A request to a bank whose open row equals the requested row issues the column command in the cycle after acceptance, with no activate or precharge. The column is zero-extended onto `addr_o`.
- R4: A request to an open bank holding a different row first issues PRE (2) with that bank on `ba_o` and `addr_o` all zero. Bit 10 low selects single-bank precharge. The ACT for the new row comes next, then the column command.
- R5: A precharge caused by a row conflict closes only the bank that conflicted. Rows open in other banks stay open and still give hits.
- R6: Exactly `cfg_trcd` NOP cycles separate an ACT from the column command that follows it (0 means back to back).
- R7: Exactly `cfg_trp` NOP cycles separate a PRE from the ACT that follows it (0 means back to back).
- R8: A pulse on `pre_all` marks all banks closed. The next access to any bank begins with ACT, not PRE.
- R9: `req_ready` is high for exactly one cycle per access, in the cycle where the column command is on `cmd_o`.
- R10: The column command is WR (4) when `req_write` is high and RD (3) when it is low.
- R11: Between accesses, and while no request is pending, `cmd_o` is NOP and `ba_o`/`addr_o` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present; held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 16 | Target row |
| req_col | input | 10 | Target column |
| req_ready | output | 1 | One-cycle pulse with the column command |
| pre_all | input | 1 | All banks were closed externally |
| cfg_trcd | input | 4 | NOP cycles after activate |
| cfg_trp | input | 4 | NOP cycles after precharge |
| cmd_o | output | 3 | Command: 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR |
| ba_o | output | 2 | Bank-select pins |
| addr_o | output | 16 | Address pins (row, column or precharge code) |

## Verification
A wrong valid flag or stored row in the bank table shows up on the very next access to that bank. The bench sees an ACT where a hit was due, a PRE where an ACT was due, or a column command with no precharge before it. Each access is compared cycle by cycle against a bench model of the open rows, so a miscounted wait appears as a command one cycle early or late. A misplaced ready pulse is caught in the cycle it occurs. Damage to a bank other than the one accessed is exposed by a later hit check on that bank.

// File: rtl/sdrt_pkg.sv
// Package: shared command and sequencer state encodings for the
// SDRAM open-row bank tracker. Command codes are visible on cmd_o.
package sdrt_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } sdr_cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_RP  = 2'd1,
        ST_WAIT_RCD = 2'd2,
        ST_RECOVER  = 2'd3
    } seq_state_e;

endpackage

// File: rtl/sdrt_bank_table.sv
// Module: sdrt_bank_table
// Holds one valid flag and one open-row register per internal bank.
// Provides a combinational lookup (open / row hit) for one bank.
// Assumes: at most one of set_en / clr_en is active per cycle; clr_all
// takes priority over both.
module sdrt_bank_table #(
    parameter int BANKS = 4,
    parameter int ROW_W = 16,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_open,
    output logic              lk_hit,
    input  logic              set_en,
    input  logic [BANK_W-1:0] set_bank,
    input  logic [ROW_W-1:0]  set_row,
    input  logic              clr_en,
    input  logic [BANK_W-1:0] clr_bank,
    input  logic              clr_all
);

    logic [BANKS-1:0]       valid_q;
    logic [BANKS*ROW_W-1:0] rows_flat;
    logic [ROW_W-1:0]       sel_row;

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic             vld_r;
        logic [ROW_W-1:0] row_r;

        // Update this bank's open-row entry.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_r <= 1'b0;
                row_r <= '0;
            end else if (clr_all) begin
                vld_r <= 1'b0;
            end else if (set_en && set_bank == BANK_W'(g)) begin
                vld_r <= 1'b1;
                row_r <= set_row;
            end else if (clr_en && clr_bank == BANK_W'(g)) begin
                vld_r <= 1'b0;
            end
        end

        assign valid_q[g]                    = vld_r;
        assign rows_flat[g*ROW_W +: ROW_W]   = row_r;
    end

    // Select the stored row of the looked-up bank.
    always_comb begin
        sel_row = rows_flat[ROW_W*int'(lk_bank) +: ROW_W];
    end

    assign lk_open = valid_q[lk_bank];
    assign lk_hit  = lk_open && (sel_row == lk_row);

    // R8
    pre_all_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (valid_q == '0));

    // R5
    other_banks_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !clr_all && !set_en) |=>
        ((valid_q | (BANKS'(1) << $past(clr_bank))) ==
         ($past(valid_q) | (BANKS'(1) << $past(clr_bank)))));

endmodule

// File: rtl/sdrt_wait_timer.sv
// Module: sdrt_wait_timer
// Down-counter for command spacing. Load sets the count; it then falls
// by one per cycle until zero. zero_o tells the sequencer it may issue.
// Assumes: load only when the sequencer issues ACT or PRE.
module sdrt_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load or count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    // R6 R7
    countdown_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdrt_sequencer.sv
// Module: sdrt_sequencer
// Accepts one access at a time, classifies it (hit / closed / conflict)
// from the bank table, and drives registered ACT, PRE, RD/WR and NOP
// commands with spacing taken from the wait timer.
// Assumes: the requester holds req_* stable until req_ready and drops
// req_valid in the ready cycle; one idle NOP cycle follows each access.
module sdrt_sequencer
    import sdrt_pkg::*;
#(
    parameter int BANKS = 4,
    parameter int ROW_W = 16,
    parameter int COL_W = 10,
    parameter int CNT_W = 4,
    localparam int BANK_W = $clog2(BANKS),
    localparam int ADDR_W = ROW_W,
    localparam int AP_BIT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    input  logic              lk_open,
    input  logic              lk_hit,
    input  logic              tmr_zero,
    input  logic [CNT_W-1:0]  cfg_trcd,
    input  logic [CNT_W-1:0]  cfg_trp,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              set_en,
    output logic [BANK_W-1:0] set_bank,
    output logic [ROW_W-1:0]  set_row,
    output logic              clr_en,
    output logic [BANK_W-1:0] clr_bank,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o
);

    seq_state_e        st_q, st_d;
    sdr_cmd_e          cmd_q, cmd_d;
    logic [BANK_W-1:0] ba_q, ba_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic              ready_q, ready_d;
    logic              latch_en;
    logic [BANK_W-1:0] lat_bank;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;
    logic              lat_wr;

    // Decide next state, next command and table/timer updates.
    always_comb begin
        st_d     = st_q;
        cmd_d    = CMD_NOP;
        ba_d     = '0;
        addr_d   = '0;
        ready_d  = 1'b0;
        latch_en = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        set_en   = 1'b0;
        set_bank = lat_bank;
        set_row  = lat_row;
        clr_en   = 1'b0;
        clr_bank = req_bank;
        unique case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    latch_en = 1'b1;
                    ba_d     = req_bank;
                    if (lk_hit) begin
                        cmd_d   = req_write ? CMD_WR : CMD_RD;
                        addr_d  = ADDR_W'(req_col);
                        ready_d = 1'b1;
                        st_d    = ST_RECOVER;
                    end else if (lk_open) begin
                        cmd_d    = CMD_PRE;
                        addr_d   = '0;
                        addr_d[AP_BIT] = 1'b0;
                        clr_en   = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = cfg_trp;
                        st_d     = ST_WAIT_RP;
                    end else begin
                        cmd_d    = CMD_ACT;
                        addr_d   = req_row;
                        set_en   = 1'b1;
                        set_bank = req_bank;
                        set_row  = req_row;
                        tmr_load = 1'b1;
                        tmr_val  = cfg_trcd;
                        st_d     = ST_WAIT_RCD;
                    end
                end
            end
            ST_WAIT_RP: begin
                if (tmr_zero) begin
                    cmd_d    = CMD_ACT;
                    ba_d     = lat_bank;
                    addr_d   = lat_row;
                    set_en   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = cfg_trcd;
                    st_d     = ST_WAIT_RCD;
                end
            end
            ST_WAIT_RCD: begin
                if (tmr_zero) begin
                    cmd_d   = lat_wr ? CMD_WR : CMD_RD;
                    ba_d    = lat_bank;
                    addr_d  = ADDR_W'(lat_col);
                    ready_d = 1'b1;
                    st_d    = ST_RECOVER;
                end
            end
            ST_RECOVER: begin
                st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Register state and the command pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            cmd_q   <= CMD_NOP;
            ba_q    <= '0;
            addr_q  <= '0;
            ready_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            cmd_q   <= cmd_d;
            ba_q    <= ba_d;
            addr_q  <= addr_d;
            ready_q <= ready_d;
        end
    end

    // Capture the accepted request for the later commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_bank <= '0;
            lat_row  <= '0;
            lat_col  <= '0;
            lat_wr   <= 1'b0;
        end else if (latch_en) begin
            lat_bank <= req_bank;
            lat_row  <= req_row;
            lat_col  <= req_col;
            lat_wr   <= req_write;
        end
    end

    assign cmd_o     = cmd_q;
    assign ba_o      = ba_q;
    assign addr_o    = addr_q;
    assign req_ready = ready_q;

    // R6
    act_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT && !tmr_zero) |=> (cmd_q == CMD_NOP));

    // R7
    pre_not_to_column_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |=> (cmd_q != CMD_RD && cmd_q != CMD_WR));

    // R2
    act_not_repeated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |=> (cmd_q != CMD_ACT && cmd_q != CMD_PRE));

    // R9
    ready_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

endmodule

// File: rtl/sdram_row_tracker.sv
// Module: sdram_row_tracker (top)
// Open-row tracker for a four-bank SDRAM: bank table, wait timer and
// command sequencer. Assumes the requester follows the hold-until-ready
// handshake and that cfg_* are stable while an access is in flight.
module sdram_row_tracker #(
    parameter int BANKS = 4,
    parameter int ROW_W = 16,
    parameter int COL_W = 10,
    parameter int CNT_W = 4,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ready,
    input  logic              pre_all,
    input  logic [CNT_W-1:0]  cfg_trcd,
    input  logic [CNT_W-1:0]  cfg_trp,
    output logic [2:0]        cmd_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ROW_W-1:0]  addr_o
);

    logic              lk_open, lk_hit;
    logic              set_en, clr_en;
    logic [BANK_W-1:0] set_bank, clr_bank;
    logic [ROW_W-1:0]  set_row;
    logic              tmr_load, tmr_zero;
    logic [CNT_W-1:0]  tmr_val, tmr_cnt;

    sdrt_bank_table #(.BANKS(BANKS), .ROW_W(ROW_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_bank  (req_bank),
        .lk_row   (req_row),
        .lk_open  (lk_open),
        .lk_hit   (lk_hit),
        .set_en   (set_en),
        .set_bank (set_bank),
        .set_row  (set_row),
        .clr_en   (clr_en),
        .clr_bank (clr_bank),
        .clr_all  (pre_all)
    );

    sdrt_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt_o    (tmr_cnt),
        .zero_o   (tmr_zero)
    );

    sdrt_sequencer #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_bank  (req_bank),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_ready (req_ready),
        .lk_open   (lk_open),
        .lk_hit    (lk_hit),
        .tmr_zero  (tmr_zero),
        .cfg_trcd  (cfg_trcd),
        .cfg_trp   (cfg_trp),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .set_en    (set_en),
        .set_bank  (set_bank),
        .set_row   (set_row),
        .clr_en    (clr_en),
        .clr_bank  (clr_bank),
        .cmd_o     (cmd_o),
        .ba_o      (ba_o),
        .addr_o    (addr_o)
    );

    // R11
    idle_pins_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == 3'd0) |-> (ba_o == '0 && addr_o == '0 && !req_ready));

    // R6 timer count is never left pending after a column command
    ready_timer_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (tmr_cnt == '0));

endmodule

// File: tb/test_sdram_row_tracker.sv
module test_sdram_row_tracker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [1:0]  req_bank;
    logic [15:0] req_row;
    logic [9:0]  req_col;
    logic        req_ready;
    logic        pre_all;
    logic [3:0]  cfg_trcd, cfg_trp;
    logic [2:0]  cmd_o;
    logic [1:0]  ba_o;
    logic [15:0] addr_o;

    int checks = 0;
    int errors = 0;

    bit          m_valid [4];
    logic [15:0] m_row   [4];

    always #4 clk = ~clk;

    sdram_row_tracker i_sdram_row_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_ready(req_ready), .pre_all(pre_all), .cfg_trcd(cfg_trcd),
        .cfg_trp(cfg_trp), .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // One access; expected sequence built from the bench's own bank model.
    task automatic access(input int b, input logic [15:0] row, input logic [9:0] col,
                          input bit wr, input string req);
        logic [2:0]  ec [64];
        logic [1:0]  eb [64];
        logic [15:0] ea [64];
        int n = 0;
        logic [2:0] rw = wr ? 3'd4 : 3'd3;
        if (m_valid[b] && m_row[b] != row) begin
            ec[n] = 3'd2; eb[n] = 2'(b); ea[n] = 16'h0; n++;
            for (int k = 0; k < int'(cfg_trp); k++) begin
                ec[n] = 3'd0; eb[n] = 2'd0; ea[n] = 16'h0; n++;
            end
        end
        if (!(m_valid[b] && m_row[b] == row)) begin
            ec[n] = 3'd1; eb[n] = 2'(b); ea[n] = row; n++;
            for (int k = 0; k < int'(cfg_trcd); k++) begin
                ec[n] = 3'd0; eb[n] = 2'd0; ea[n] = 16'h0; n++;
            end
        end
        ec[n] = rw; eb[n] = 2'(b); ea[n] = {6'd0, col}; n++;
        m_valid[b] = 1'b1;
        m_row[b]   = row;

        @(negedge clk);
        check(cmd_o == 3'd0 && !req_ready, "R11", "idle before access cmd", cmd_o, 0);
        req_valid = 1'b1; req_write = wr; req_bank = 2'(b); req_row = row; req_col = col;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(cmd_o == ec[i], req, $sformatf("cmd at step %0d", i), cmd_o, ec[i]);
            check(ba_o == eb[i] && addr_o == ea[i], req,
                  $sformatf("bank/addr at step %0d", i), {ba_o, addr_o}, {eb[i], ea[i]});
            check(req_ready == (i == n - 1), "R9", $sformatf("ready at step %0d", i),
                  req_ready, (i == n - 1));
            if (i == n - 1) req_valid = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(cmd_o == 3'd0, "R1", "cmd after reset", cmd_o, 0);
        check(!req_ready, "R1", "ready after reset", req_ready, 0);
    endtask

    task automatic t_closed_then_hit();
        access(0, 16'h1234, 10'h011, 1'b0, "R2 R6");
        access(0, 16'h1234, 10'h3FF, 1'b1, "R3 R10");
        access(0, 16'h1234, 10'h022, 1'b0, "R3");
    endtask

    task automatic t_conflict_keeps_others();
        access(1, 16'hBEEF, 10'h005, 1'b1, "R2 R10");
        access(0, 16'h0042, 10'h100, 1'b0, "R4 R7");
        access(1, 16'hBEEF, 10'h006, 1'b0, "R5");
        access(0, 16'h0042, 10'h101, 1'b1, "R5 R3");
    endtask

    task automatic t_pre_all();
        @(negedge clk);
        pre_all = 1'b1;
        @(negedge clk);
        pre_all = 1'b0;
        for (int k = 0; k < 4; k++) m_valid[k] = 1'b0;
        access(1, 16'hBEEF, 10'h007, 1'b0, "R8");
        access(0, 16'h0042, 10'h008, 1'b0, "R8");
    endtask

    task automatic t_zero_and_long_waits();
        cfg_trcd = 4'd0; cfg_trp = 4'd0;
        access(1, 16'h7777, 10'h009, 1'b1, "R4 R6 R7");
        access(3, 16'hFFFF, 10'h000, 1'b0, "R2 R6");
        cfg_trcd = 4'd5; cfg_trp = 4'd7;
        access(3, 16'h0000, 10'h1AB, 1'b1, "R4 R7");
        access(2, 16'h8001, 10'h2CD, 1'b0, "R2 R6");
    endtask

    task automatic t_idle();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check(cmd_o == 3'd0 && ba_o == 2'd0 && addr_o == 16'h0, "R11",
                  "idle pins", {cmd_o, ba_o, addr_o}, 0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_bank = 2'd0;
        req_row = 16'h0; req_col = 10'h0; pre_all = 1'b0;
        cfg_trcd = 4'd2; cfg_trp = 4'd3;
        for (int k = 0; k < 4; k++) begin m_valid[k] = 1'b0; m_row[k] = 16'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_closed_then_hit();
        t_conflict_keeps_others();
        t_pre_all();
        t_zero_and_long_waits();
        t_idle();
        finish_run();
    end

endmodule